// File: doc/BRIEF.md
# Rename Buffer with In-Order Retirement

This block gives a two-way issue core its register renaming and retirement. Each cycle, up to two issuing instructions that produce a result each claim a free rename buffer entry. The map table then points each destination register at its new entry. Source operands are resolved through the same map. An unmapped register returns its committed value. A mapped register returns the buffer value once the result has arrived, and otherwise returns the buffer tag for a waiting consumer.

Execution results come back by tag on two write ports. Each one marks its entry complete, and the entry stays occupied. The buffer is a circular queue. Entries leave from the head in the order they were claimed, at most two per cycle, and only once complete. A retiring entry that is still the live mapping of its register commits its value to the register file and hands the register back to its committed state. An entry that a younger rename has replaced leaves silently and touches neither the register file nor the map.

Top module: `rb_rename_top`

## Requirements
- R1: Entries are claimed in circular queue order. Lane a is the older lane, and when it requests it receives the entry at the queue tail. Lane b receives the entry after that one when lane a also requests, and the tail entry when lane b requests alone.
- R2: When more lanes request than there are free entries, `iss_stall` is 1, neither lane claims an entry, and the map is unchanged. Entries freed by retirement in a cycle become claimable from the next cycle.
- R3: After an issue, the destination register is mapped to its new entry. When both lanes name the same destination in one cycle, lane b's entry becomes the mapping.
- R4: A result write on a port with `wr_en` set stores the data into the tagged entry and marks it complete from the next cycle. The entry stays occupied until it retires.
- R5: Only a complete entry at the queue head retires. A complete entry behind an incomplete older one waits (`ret_fire` bit 0 is 0).
- R6: When the head entry and the entry after it are both complete, both retire in the same cycle (`ret_fire` = 2'b11).
- R7: A retiring entry that is still the live mapping of its register writes its value into the register file and sets the matching `ret_upd` bit. The mapping is cleared, unless the same register is renamed in that same cycle.
- R8: A retiring entry that has been replaced by a younger rename leaves the register file and the map untouched, and its `ret_upd` bit is 0.
- R9: A lookup of an unmapped register returns the committed value with ready 1. A lookup that hits a complete entry returns its value with ready 1. A lookup that hits an incomplete entry returns its tag, zero-extended, with ready 0. Lookups see the map as it stood at the start of the cycle.
- R10: Synchronous reset empties the queue, clears every mapping and zeroes every register, so lookups return 0 with ready 1 and no entry retires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_req | input | 2 | Bit 0 is a lane a claim and bit 1 is a lane b claim; lane a is older |
| iss_dst_a | input | 3 | Destination register of lane a |
| iss_dst_b | input | 3 | Destination register of lane b |
| iss_stall | output | 1 | Request cannot be granted this cycle |
| iss_tag_a | output | 2 | Entry given to lane a |
| iss_tag_b | output | 2 | Entry given to lane b |
| wr_en | input | 2 | Result write enables; bit 0 is port a and bit 1 is port b |
| wr_tag_a | input | 2 | Entry targeted by result port a |
| wr_tag_b | input | 2 | Entry targeted by result port b |
| wr_data_a | input | 16 | Result data on port a |
| wr_data_b | input | 16 | Result data on port b |
| lk_reg_a | input | 3 | Source register looked up on port a |
| lk_reg_b | input | 3 | Source register looked up on port b |
| lk_rdy_a | output | 1 | Port a returns a value (1) or a tag (0) |
| lk_rdy_b | output | 1 | Port b returns a value (1) or a tag (0) |
| lk_val_a | output | 16 | Value, or zero-extended tag, for port a |
| lk_val_b | output | 16 | Value, or zero-extended tag, for port b |
| ret_fire | output | 2 | Bit 0 means the head entry retires; bit 1 means the entry after it also retires |
| ret_upd | output | 2 | Matching retiring entry updates the register file |

## Verification
The bench builds the block with its defaults: eight registers, four entries and two lanes. With only four entries, stalls and queue wrap-around come up every few cycles. Random destinations are drawn from half of the register space, so renames of the same register in one cycle and across cycles happen often, and many retirements are silent ones. A directed opening covers the in-cycle double rename, a younger result that completes first, and a double retirement.

// File: rtl/rb_pkg.sv
package rb_pkg;
    localparam int ARCH_REGS = 8;
    localparam int DATA_W    = 16;
    localparam int ENTRIES   = 4;
    localparam int LANES     = 2;

    localparam int AREG_W = $clog2(ARCH_REGS);
    localparam int TAG_W  = $clog2(ENTRIES);
    localparam int CNT_W  = $clog2(ENTRIES + 1);

    typedef logic [AREG_W-1:0] areg_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic renamed;
        tag_t tag;
    } map_ent_t;

    typedef struct packed {
        logic  busy;
        logic  done;
        areg_t areg;
        data_t value;
    } buf_ent_t;

    function automatic tag_t tag_step(tag_t t, int unsigned k);
        int unsigned s;
        s = (int'(t) + k) % ENTRIES;
        return tag_t'(s);
    endfunction
endpackage

// File: rtl/rb_queue_ctrl.sv
module rb_queue_ctrl
    import rb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [LANES-1:0]   req,
    input  logic [ENTRIES-1:0] done_vec,
    output logic               stall,
    output logic [LANES-1:0]   alloc,
    output tag_t               tag_a,
    output tag_t               tag_b,
    output logic [LANES-1:0]   fire,
    output tag_t               ret_tag_a,
    output tag_t               ret_tag_b
);
    tag_t head_q, tail_q;
    cnt_t cnt_q;
    int unsigned n_req, n_free, n_alloc, n_ret;

    always_comb begin
        n_req   = int'(req[0]) + int'(req[1]);
        n_free  = ENTRIES - int'(cnt_q);
        stall   = (n_req > n_free);
        alloc   = stall ? '0 : req;
        n_alloc = int'(alloc[0]) + int'(alloc[1]);
        tag_a   = tail_q;
        tag_b   = req[0] ? tag_step(tail_q, 1) : tail_q;
        ret_tag_a = head_q;
        ret_tag_b = tag_step(head_q, 1);
        fire[0] = (cnt_q != '0) && done_vec[head_q];
        fire[1] = fire[0] && (int'(cnt_q) >= 2) && done_vec[ret_tag_b];
        n_ret   = int'(fire[0]) + int'(fire[1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= tag_step(head_q, n_ret);
            tail_q <= tag_step(tail_q, n_alloc);
            cnt_q  <= cnt_t'(int'(cnt_q) + n_alloc - n_ret);
        end
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) <= ENTRIES);

    p_tail_hold_r2: assert property (@(posedge clk) disable iff (rst)
        stall |=> tail_q == $past(tail_q));
endmodule

// File: rtl/rb_entry_store.sv
module rb_entry_store
    import rb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [LANES-1:0]   alloc,
    input  tag_t               tag_a,
    input  tag_t               tag_b,
    input  areg_t              dst_a,
    input  areg_t              dst_b,
    input  logic [LANES-1:0]   wr_en,
    input  tag_t               wr_tag_a,
    input  tag_t               wr_tag_b,
    input  data_t              wr_data_a,
    input  data_t              wr_data_b,
    input  logic [ENTRIES-1:0] free_vec,
    output buf_ent_t           ents [ENTRIES],
    output logic [ENTRIES-1:0] done_vec
);
    buf_ent_t ent_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        logic hit_a, hit_b, wa, wb;
        assign hit_a = alloc[0] && (tag_a == tag_t'(i));
        assign hit_b = alloc[1] && (tag_b == tag_t'(i));
        assign wa    = wr_en[0] && (wr_tag_a == tag_t'(i)) && ent_q[i].busy;
        assign wb    = wr_en[1] && (wr_tag_b == tag_t'(i)) && ent_q[i].busy;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= '0;
            end else if (hit_b) begin
                ent_q[i] <= '{busy: 1'b1, done: 1'b0, areg: dst_b, value: '0};
            end else if (hit_a) begin
                ent_q[i] <= '{busy: 1'b1, done: 1'b0, areg: dst_a, value: '0};
            end else if (free_vec[i]) begin
                ent_q[i].busy <= 1'b0;
                ent_q[i].done <= 1'b0;
            end else if (wb) begin
                ent_q[i].done  <= 1'b1;
                ent_q[i].value <= wr_data_b;
            end else if (wa) begin
                ent_q[i].done  <= 1'b1;
                ent_q[i].value <= wr_data_a;
            end
        end

        assign ents[i]     = ent_q[i];
        assign done_vec[i] = ent_q[i].done;

        p_result_marks_done_r4: assert property (@(posedge clk) disable iff (rst)
            (wa || wb) && !free_vec[i] && !hit_a && !hit_b |=> ent_q[i].done && ent_q[i].busy);
    end
endmodule

// File: rtl/rb_map_table.sv
module rb_map_table
    import rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] alloc,
    input  areg_t            dst_a,
    input  areg_t            dst_b,
    input  tag_t             tag_a,
    input  tag_t             tag_b,
    input  logic [LANES-1:0] clr,
    input  areg_t            clr_reg_a,
    input  areg_t            clr_reg_b,
    output map_ent_t         map_q [ARCH_REGS]
);
    for (genvar r = 0; r < ARCH_REGS; r++) begin : g_map
        always_ff @(posedge clk) begin
            if (rst) begin
                map_q[r] <= '0;
            end else if (alloc[1] && dst_b == areg_t'(r)) begin
                map_q[r] <= '{renamed: 1'b1, tag: tag_b};
            end else if (alloc[0] && dst_a == areg_t'(r)) begin
                map_q[r] <= '{renamed: 1'b1, tag: tag_a};
            end else if ((clr[0] && clr_reg_a == areg_t'(r)) ||
                         (clr[1] && clr_reg_b == areg_t'(r))) begin
                map_q[r] <= '0;
            end
        end
    end

    p_younger_wins_r3: assert property (@(posedge clk) disable iff (rst)
        alloc[0] && alloc[1] && (dst_a == dst_b) |=>
        map_q[$past(dst_b)].renamed && map_q[$past(dst_b)].tag == $past(tag_b));
endmodule

// File: rtl/rb_rename_top.sv
module rb_rename_top
    import rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        iss_req,
    input  logic [AREG_W-1:0] iss_dst_a,
    input  logic [AREG_W-1:0] iss_dst_b,
    output logic              iss_stall,
    output logic [TAG_W-1:0]  iss_tag_a,
    output logic [TAG_W-1:0]  iss_tag_b,
    input  logic [1:0]        wr_en,
    input  logic [TAG_W-1:0]  wr_tag_a,
    input  logic [TAG_W-1:0]  wr_tag_b,
    input  logic [DATA_W-1:0] wr_data_a,
    input  logic [DATA_W-1:0] wr_data_b,
    input  logic [AREG_W-1:0] lk_reg_a,
    input  logic [AREG_W-1:0] lk_reg_b,
    output logic              lk_rdy_a,
    output logic              lk_rdy_b,
    output logic [DATA_W-1:0] lk_val_a,
    output logic [DATA_W-1:0] lk_val_b,
    output logic [1:0]        ret_fire,
    output logic [1:0]        ret_upd
);
    logic [LANES-1:0]   alloc;
    logic [ENTRIES-1:0] done_vec, free_vec;
    tag_t               rtag [LANES];
    buf_ent_t           ents [ENTRIES];
    map_ent_t           map_q [ARCH_REGS];
    data_t              rf_q [ARCH_REGS];
    logic [LANES-1:0]   clr;
    areg_t              lk_reg [LANES];
    logic               lk_rdy [LANES];
    data_t              lk_val [LANES];

    rb_queue_ctrl u_queue (
        .clk(clk), .rst(rst), .req(iss_req), .done_vec(done_vec),
        .stall(iss_stall), .alloc(alloc), .tag_a(iss_tag_a), .tag_b(iss_tag_b),
        .fire(ret_fire), .ret_tag_a(rtag[0]), .ret_tag_b(rtag[1])
    );

    rb_entry_store u_store (
        .clk(clk), .rst(rst), .alloc(alloc), .tag_a(iss_tag_a), .tag_b(iss_tag_b),
        .dst_a(iss_dst_a), .dst_b(iss_dst_b), .wr_en(wr_en),
        .wr_tag_a(wr_tag_a), .wr_tag_b(wr_tag_b),
        .wr_data_a(wr_data_a), .wr_data_b(wr_data_b),
        .free_vec(free_vec), .ents(ents), .done_vec(done_vec)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_ret
        buf_ent_t e;
        assign e = ents[rtag[k]];
        assign ret_upd[k] = ret_fire[k] && map_q[e.areg].renamed && (map_q[e.areg].tag == rtag[k]);
        assign clr[k]     = ret_upd[k];

        p_update_only_on_fire_r7: assert property (@(posedge clk) disable iff (rst)
            ret_upd[k] |-> ret_fire[k] && e.done);
        p_silent_keeps_rf_r8: assert property (@(posedge clk) disable iff (rst)
            ret_fire[k] && !ret_upd[0] && !ret_upd[1] |=> rf_q[$past(e.areg)] == $past(rf_q[e.areg]));
    end

    always_comb begin
        free_vec = '0;
        for (int k = 0; k < LANES; k++)
            if (ret_fire[k]) free_vec[rtag[k]] = 1'b1;
    end

    rb_map_table u_map (
        .clk(clk), .rst(rst), .alloc(alloc), .dst_a(iss_dst_a), .dst_b(iss_dst_b),
        .tag_a(iss_tag_a), .tag_b(iss_tag_b), .clr(clr),
        .clr_reg_a(g_ret[0].e.areg), .clr_reg_b(g_ret[1].e.areg), .map_q(map_q)
    );

    for (genvar r = 0; r < ARCH_REGS; r++) begin : g_rf
        always_ff @(posedge clk) begin
            if (rst) begin
                rf_q[r] <= '0;
            end else if (ret_upd[1] && g_ret[1].e.areg == areg_t'(r)) begin
                rf_q[r] <= g_ret[1].e.value;
            end else if (ret_upd[0] && g_ret[0].e.areg == areg_t'(r)) begin
                rf_q[r] <= g_ret[0].e.value;
            end
        end

        p_map_target_live_r3: assert property (@(posedge clk) disable iff (rst)
            map_q[r].renamed |-> ents[map_q[r].tag].busy && ents[map_q[r].tag].areg == areg_t'(r));
    end

    assign lk_reg[0] = lk_reg_a;
    assign lk_reg[1] = lk_reg_b;

    for (genvar k = 0; k < LANES; k++) begin : g_lk
        map_ent_t m;
        assign m = map_q[lk_reg[k]];
        always_comb begin
            if (!m.renamed) begin
                lk_rdy[k] = 1'b1;
                lk_val[k] = rf_q[lk_reg[k]];
            end else if (ents[m.tag].done) begin
                lk_rdy[k] = 1'b1;
                lk_val[k] = ents[m.tag].value;
            end else begin
                lk_rdy[k] = 1'b0;
                lk_val[k] = data_t'(m.tag);
            end
        end
    end

    assign lk_rdy_a = lk_rdy[0];
    assign lk_rdy_b = lk_rdy[1];
    assign lk_val_a = lk_val[0];
    assign lk_val_b = lk_val[1];

    p_second_needs_first_r5: assert property (@(posedge clk) disable iff (rst)
        ret_fire[1] |-> ret_fire[0]);
endmodule

// File: tb/rb_rename_top_tb.sv
module rb_rename_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 8;
    localparam int NE   = 4;

    logic clk = 0, rst = 1;
    logic [1:0]  iss_req = 0;
    logic [2:0]  iss_dst_a = 0, iss_dst_b = 0;
    logic        iss_stall;
    logic [1:0]  iss_tag_a, iss_tag_b;
    logic [1:0]  wr_en = 0;
    logic [1:0]  wr_tag_a = 0, wr_tag_b = 0;
    logic [15:0] wr_data_a = 0, wr_data_b = 0;
    logic [2:0]  lk_reg_a = 0, lk_reg_b = 0;
    logic        lk_rdy_a, lk_rdy_b;
    logic [15:0] lk_val_a, lk_val_b;
    logic [1:0]  ret_fire, ret_upd;

    int errors = 0, checks = 0;
    bit finished = 0;

    int mren [NREG], mtg [NREG], mrf [NREG];
    int mbusy [NE], mvld [NE], mar [NE], mval [NE];
    int mhead, mtail, mcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rb_rename_top dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) begin mren[i] = 0; mtg[i] = 0; mrf[i] = 0; end
        for (int i = 0; i < NE; i++) begin mbusy[i] = 0; mvld[i] = 0; mar[i] = 0; mval[i] = 0; end
        mhead = 0; mtail = 0; mcnt = 0;
    endtask

    function automatic int exp_val(int r);
        if (!mren[r]) return mrf[r];
        if (mvld[mtg[r]]) return mval[mtg[r]];
        return mtg[r];
    endfunction

    function automatic int exp_rdy(int r);
        return (!mren[r] || mvld[mtg[r]]) ? 1 : 0;
    endfunction

    task automatic step(input int ra, input int rb, input int da, input int db,
                        input int wa, input int wb, input int ta, input int tb,
                        input int xa, input int xb, input int la, input int lb);
        int f0, f1, h1, u0, u1, st, eta, etb, nreq;
        @(negedge clk);
        iss_req = {rb[0], ra[0]}; iss_dst_a = da[2:0]; iss_dst_b = db[2:0];
        wr_en = {wb[0], wa[0]}; wr_tag_a = ta[1:0]; wr_tag_b = tb[1:0];
        wr_data_a = xa[15:0]; wr_data_b = xb[15:0];
        lk_reg_a = la[2:0]; lk_reg_b = lb[2:0];
        #1;
        h1 = (mhead + 1) % NE;
        f0 = (mcnt >= 1 && mvld[mhead]) ? 1 : 0;
        f1 = (f0 && mcnt >= 2 && mvld[h1]) ? 1 : 0;
        u0 = (f0 && mren[mar[mhead]] && mtg[mar[mhead]] == mhead) ? 1 : 0;
        u1 = (f1 && mren[mar[h1]] && mtg[mar[h1]] == h1) ? 1 : 0;
        nreq = ra + rb;
        st = (nreq > NE - mcnt) ? 1 : 0;
        eta = mtail;
        etb = ra ? (mtail + 1) % NE : mtail;
        chk(iss_stall == st[0], "R2 stall", iss_stall, st);
        if (!st && ra) chk(iss_tag_a == eta[1:0], "R1 tag a", iss_tag_a, eta);
        if (!st && rb) chk(iss_tag_b == etb[1:0], "R1 tag b", iss_tag_b, etb);
        chk(lk_rdy_a == exp_rdy(la) && lk_val_a == exp_val(la), "R9 lookup a", {lk_rdy_a, lk_val_a}, {exp_rdy(la), exp_val(la)});
        chk(lk_rdy_b == exp_rdy(lb) && lk_val_b == exp_val(lb), "R9 lookup b", {lk_rdy_b, lk_val_b}, {exp_rdy(lb), exp_val(lb)});
        chk(ret_fire[0] == f0[0], "R5 head retire", ret_fire[0], f0);
        chk(ret_fire[1] == f1[0], "R6 pair retire", ret_fire[1], f1);
        chk(ret_upd[0] == u0[0], u0 ? "R7 update a" : "R8 silent a", ret_upd[0], u0);
        chk(ret_upd[1] == u1[0], u1 ? "R7 update b" : "R8 silent b", ret_upd[1], u1);
        if (u0) begin mrf[mar[mhead]] = mval[mhead]; mren[mar[mhead]] = 0; end
        if (u1) begin mrf[mar[h1]] = mval[h1]; mren[mar[h1]] = 0; end
        if (f0) begin mbusy[mhead] = 0; mvld[mhead] = 0; end
        if (f1) begin mbusy[h1] = 0; mvld[h1] = 0; end
        if (wa && mbusy[ta]) begin mvld[ta] = 1; mval[ta] = xa & 16'hFFFF; end
        if (wb && mbusy[tb]) begin mvld[tb] = 1; mval[tb] = xb & 16'hFFFF; end
        if (!st) begin
            if (ra) begin mbusy[eta] = 1; mvld[eta] = 0; mar[eta] = da; mren[da] = 1; mtg[da] = eta; end
            if (rb) begin mbusy[etb] = 1; mvld[etb] = 0; mar[etb] = db; mren[db] = 1; mtg[db] = etb; end
            mtail = (mtail + ra + rb) % NE;
            mcnt = mcnt + ra + rb;
        end
        mhead = (mhead + f0 + f1) % NE;
        mcnt = mcnt - f0 - f1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed, pend [NE], np, wa, wb, ta, tb, pa;
        seed = $urandom(32'h5eed);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R10: reset state seen at the ports
        #1;
        chk(lk_rdy_a == 1 && lk_val_a == 0, "R10 reset lookup", lk_val_a, 0);
        chk(ret_fire == 2'b00, "R10 reset no retire", ret_fire, 0);
        // directed: two renames of register 3 in one cycle
        step(1, 1, 3, 3, 0, 0, 0, 0, 0, 0, 3, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 3);
        chk(lk_rdy_a == 0 && lk_val_a == 1, "R3 younger mapping", lk_val_a, 1);
        // younger result first: must wait behind the head
        step(0, 0, 0, 0, 0, 1, 0, 1, 0, 16'h55, 3, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 0);
        chk(lk_rdy_a == 1 && lk_val_a == 16'h55, "R4 result stored", lk_val_a, 16'h55);
        chk(ret_fire[0] == 0, "R5 younger waits", ret_fire, 0);
        step(0, 0, 0, 0, 1, 0, 0, 0, 16'h11, 0, 3, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 3);
        chk(ret_fire == 2'b11 && ret_upd == 2'b10, "R6 pair with R8 silent older", {ret_fire, ret_upd}, 4'b1110);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3, 3);
        chk(lk_rdy_a == 1 && lk_val_a == 16'h55, "R7 committed value", lk_val_a, 16'h55);
        // fill the queue then request more
        step(1, 1, 1, 2, 0, 0, 0, 0, 0, 0, 1, 2);
        step(1, 1, 4, 5, 0, 0, 0, 0, 0, 0, 4, 5);
        step(1, 0, 6, 0, 0, 0, 0, 0, 0, 0, 6, 1);
        chk(iss_stall == 1, "R2 full queue stall", iss_stall, 1);
        // random phase
        for (int c = 0; c < 3000; c++) begin
            np = 0;
            for (int i = 0; i < NE; i++) if (mbusy[i] && !mvld[i]) begin pend[np] = i; np++; end
            wa = 0; wb = 0; ta = 0; tb = 0;
            if (np > 0 && ($urandom % 3) != 0) begin
                pa = $urandom % np; wa = 1; ta = pend[pa];
                if (np > 1 && ($urandom % 2)) begin wb = 1; tb = pend[(pa + 1 + ($urandom % (np - 1))) % np]; end
            end
            step($urandom % 2, $urandom % 2, $urandom % 4, $urandom % 4, wa, wb, ta, tb,
                 $urandom % 65536, $urandom % 65536, $urandom % NREG, $urandom % NREG);
        end
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule